// File: doc/BRIEF.md
# Asynchronous Interrupt Arbiter

This block keeps track of the asynchronous interrupt sources of a processor core and decides, at each instruction boundary, whether the exception entry logic should take an interrupt. There are two kinds of source. The first is a level-sensitive external line, which stays pending for as long as it is driven high. The second is a timer expiry pulse, which is pending until one interrupt has been delivered for it. The arbiter also watches the status-word bits it depends on: the external-enable bit and the two floating-point exception mode bits. It also watches the floating-point exception summary flag.

At a boundary, the arbiter picks the winning source. An imprecise floating-point enabled condition has the highest priority. The external line comes next, and the timer comes last. The arbiter then raises a request that carries a vector offset and the bits that entry must set in the saved status word. The request is held, unchanged, until the entry logic acknowledges it. While it is held, no second request can be queued.

Status changes need no new event. A source that stays pending while it is disabled is delivered at the first boundary after the enable bit returns to 1.

Top module: `async_irq_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `req_valid` is 0 and no source is pending, so a boundary with no new event raises no request.
- R2: A request is issued only when `insn_boundary` is 1 and no request is outstanding. `req_valid` rises in the cycle after that boundary. The request then keeps `req_vector` and `req_stat_set` stable until the cycle in which `req_ack` is 1, and `req_valid` is 0 in the cycle after the acknowledge.
- R3: The floating-point condition is present when `sts_fe` is nonzero and `fp_summary` is 1. It wins over every other source, whatever the value of `sts_ee`. It requests vector 0x0700 with `req_stat_set` bit 11 (FP enabled) and bit 16 (subsequent instruction) set, which is the value 0x0001_0800.
- R4: External and timer requests are issued only when `sts_ee` is 1. With `sts_ee` at 0 and no floating-point condition, a boundary raises no request.
- R5: The external source requests vector 0x0500 and the timer requests vector 0x0900, both with `req_stat_set` equal to 0. When both are pending, the external source wins.
- R6: The external pending state follows `ext_line` one cycle later. It is cleared only when the line falls, and acknowledging an external request does not clear it.
- R7: A `dec_expire` pulse sets the timer pending state. Acknowledging a timer request clears it, so the timer is taken once per expiry. If an expiry arrives in the same cycle as that acknowledge, the timer stays pending.
- R8: A source that was pending while disabled is delivered at the first boundary after `sts_ee` becomes 1, without a new event.
- R9: While a request is outstanding, further boundaries and new events neither alter it nor queue a second request. A pending source that is still present is delivered by a later boundary after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_line | input | 1 | Level-sensitive external interrupt line |
| dec_expire | input | 1 | One-cycle timer expiry pulse |
| sts_ee | input | 1 | External-enable bit of the status word |
| sts_fe | input | 2 | Floating-point exception mode bits of the status word |
| fp_summary | input | 1 | Floating-point enabled-exception summary flag |
| insn_boundary | input | 1 | Instruction boundary strobe: the cycle in which an interrupt may be taken |
| req_ack | input | 1 | Entry logic has taken the outstanding request |
| req_valid | output | 1 | Interrupt request outstanding |
| req_vector | output | VEC_W | Vector offset of the request |
| req_stat_set | output | STAT_W | Bits that entry sets in the saved status word |

## Verification
Each result has a fixed due cycle:
- A line level or expiry pulse becomes pending at the first clock edge after it is driven.
- A boundary strobe raises `req_valid` at the next edge.
- An acknowledge drops `req_valid` and, for a timer request, consumes the timer at that same edge.

The bench drives every input just after a falling edge and samples the outputs on falling edges. Every result is therefore read half a cycle after the edge that produced it. The monitor matches each rising `req_valid` against the next expected vector and status value, in the order the driver queued them. The bench checks directly the cases where no request is due, and the cases where a held request must stay unchanged.

// File: rtl/async_irq_pkg.sv
// Package: shared types for the asynchronous interrupt arbiter.
// Assumes: the source code is only used inside this block.
package async_irq_pkg;

    // Source that owns (or would own) the interrupt request
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FP   = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } irq_src_e;

endpackage

// File: rtl/irq_pending_track.sv
// Module: irq_pending_track
// Purpose: holds the pending state of the external line and of the timer.
// Assumes: ext_line is already synchronous to clk. dec_expire lasts one
// cycle per expiry. consume_dec is 1 only in the cycle in which a timer
// request is acknowledged.
module irq_pending_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_line,
    input  logic dec_expire,
    input  logic consume_dec,
    output logic ext_pend,
    output logic dec_pend
);

    // External pending follows the line level; delivery never clears it
    always_ff @(posedge clk) begin
        if (!rst_n) ext_pend <= 1'b0;
        else        ext_pend <= ext_line;
    end

    // Timer pending: a new expiry is set before any consume, so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n)           dec_pend <= 1'b0;
        else if (dec_expire)  dec_pend <= 1'b1;
        else if (consume_dec) dec_pend <= 1'b0;
    end

    // R7
    dec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pend && !consume_dec |=> dec_pend);

    // R7
    dec_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_expire |=> dec_pend);

endmodule

// File: rtl/irq_prio_select.sv
// Module: irq_prio_select
// Purpose: combinational choice of the winning source, with its vector and
// saved-status bits.
// Assumes: the inputs are stable in the cycle they are used. The result only
// takes effect when the request holder is idle and a boundary strobe arrives.
module irq_prio_select
    import async_irq_pkg::*;
#(
    parameter int FE_W       = 2,
    parameter int VEC_W      = 16,
    parameter int STAT_W     = 32,
    parameter int FPEN_BIT   = 11,
    parameter int SUBSEQ_BIT = 16,
    parameter logic [VEC_W-1:0] VEC_FP  = 16'h0700,
    parameter logic [VEC_W-1:0] VEC_EXT = 16'h0500,
    parameter logic [VEC_W-1:0] VEC_DEC = 16'h0900
) (
    input  logic              sts_ee,
    input  logic [FE_W-1:0]   sts_fe,
    input  logic              fp_summary,
    input  logic              ext_pend,
    input  logic              dec_pend,
    output irq_src_e          cand_src,
    output logic [VEC_W-1:0]  cand_vec,
    output logic [STAT_W-1:0] cand_set
);

    localparam logic [STAT_W-1:0] FP_SET =
        (STAT_W'(1) << FPEN_BIT) | (STAT_W'(1) << SUBSEQ_BIT);

    logic fp_cond;

    // Imprecise floating-point condition: any exception mode plus summary
    always_comb fp_cond = (|sts_fe) && fp_summary;

    // Fixed priority: floating-point, then external, then timer
    always_comb begin
        cand_src = SRC_NONE;
        cand_vec = '0;
        cand_set = '0;
        if (fp_cond) begin
            cand_src = SRC_FP;
            cand_vec = VEC_FP;
            cand_set = FP_SET;
        end else if (sts_ee && ext_pend) begin
            cand_src = SRC_EXT;
            cand_vec = VEC_EXT;
        end else if (sts_ee && dec_pend) begin
            cand_src = SRC_DEC;
            cand_vec = VEC_DEC;
        end
    end

endmodule

// File: rtl/irq_req_hold.sv
// Module: irq_req_hold
// Purpose: captures the winning candidate at a boundary and holds it until
// it is acknowledged.
// Assumes: req_ack is only meaningful while req_valid is 1. A request is
// never issued in the same cycle as the acknowledge that retires the
// previous one.
module irq_req_hold
    import async_irq_pkg::*;
#(
    parameter int VEC_W  = 16,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_boundary,
    input  logic              req_ack,
    input  irq_src_e          cand_src,
    input  logic [VEC_W-1:0]  cand_vec,
    input  logic [STAT_W-1:0] cand_set,
    output logic              req_valid,
    output logic [VEC_W-1:0]  req_vector,
    output logic [STAT_W-1:0] req_stat_set,
    output logic              consume_dec
);

    irq_src_e held_src;
    logic     take;
    logic     retire;

    // Issue only at a boundary, only when idle, and only if a source wins
    always_comb take = insn_boundary && !req_valid && (cand_src != SRC_NONE);

    // An acknowledge retires the outstanding request
    always_comb retire = req_valid && req_ack;

    // Tell the pending tracker that a timer request was taken
    always_comb consume_dec = retire && (held_src == SRC_DEC);

    // Request register: load on take, clear on retire, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid    <= 1'b0;
            req_vector   <= '0;
            req_stat_set <= '0;
            held_src     <= SRC_NONE;
        end else if (take) begin
            req_valid    <= 1'b1;
            req_vector   <= cand_vec;
            req_stat_set <= cand_set;
            held_src     <= cand_src;
        end else if (retire) begin
            req_valid    <= 1'b0;
            held_src     <= SRC_NONE;
        end
    end

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_vector) && $stable(req_stat_set));

    // R2
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ack |=> !req_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !insn_boundary |=> !req_valid);

endmodule

// File: rtl/async_irq_arbiter.sv
// Module: async_irq_arbiter (top)
// Purpose: tracks the asynchronous interrupt sources, picks the winner at
// each instruction boundary, and holds one request for the exception entry
// logic.
// Assumes: the status-word bits come from storage outside this block. Entry
// clears sts_ee outside this block, so the arbiter issues nothing more from
// the external line or the timer until software sets sts_ee again.
module async_irq_arbiter
    import async_irq_pkg::*;
#(
    parameter int FE_W       = 2,
    parameter int VEC_W      = 16,
    parameter int STAT_W     = 32,
    parameter int FPEN_BIT   = 11,
    parameter int SUBSEQ_BIT = 16,
    parameter logic [VEC_W-1:0] VEC_FP  = 16'h0700,
    parameter logic [VEC_W-1:0] VEC_EXT = 16'h0500,
    parameter logic [VEC_W-1:0] VEC_DEC = 16'h0900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_line,
    input  logic              dec_expire,
    input  logic              sts_ee,
    input  logic [FE_W-1:0]   sts_fe,
    input  logic              fp_summary,
    input  logic              insn_boundary,
    input  logic              req_ack,
    output logic              req_valid,
    output logic [VEC_W-1:0]  req_vector,
    output logic [STAT_W-1:0] req_stat_set
);

    logic              ext_pend;
    logic              dec_pend;
    logic              consume_dec;
    irq_src_e          cand_src;
    logic [VEC_W-1:0]  cand_vec;
    logic [STAT_W-1:0] cand_set;

    irq_pending_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_line    (ext_line),
        .dec_expire  (dec_expire),
        .consume_dec (consume_dec),
        .ext_pend    (ext_pend),
        .dec_pend    (dec_pend)
    );

    irq_prio_select #(
        .FE_W       (FE_W),
        .VEC_W      (VEC_W),
        .STAT_W     (STAT_W),
        .FPEN_BIT   (FPEN_BIT),
        .SUBSEQ_BIT (SUBSEQ_BIT),
        .VEC_FP     (VEC_FP),
        .VEC_EXT    (VEC_EXT),
        .VEC_DEC    (VEC_DEC)
    ) u_sel (
        .sts_ee     (sts_ee),
        .sts_fe     (sts_fe),
        .fp_summary (fp_summary),
        .ext_pend   (ext_pend),
        .dec_pend   (dec_pend),
        .cand_src   (cand_src),
        .cand_vec   (cand_vec),
        .cand_set   (cand_set)
    );

    irq_req_hold #(
        .VEC_W  (VEC_W),
        .STAT_W (STAT_W)
    ) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .insn_boundary (insn_boundary),
        .req_ack       (req_ack),
        .cand_src      (cand_src),
        .cand_vec      (cand_vec),
        .cand_set      (cand_set),
        .req_valid     (req_valid),
        .req_vector    (req_vector),
        .req_stat_set  (req_stat_set),
        .consume_dec   (consume_dec)
    );

    // R3
    fp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_boundary && !req_valid && (|sts_fe) && fp_summary
        |=> req_valid && req_vector == VEC_FP);

    // R4
    ee_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_boundary && !req_valid && !((|sts_fe) && fp_summary) && !sts_ee
        |=> !req_valid);

    // R5
    ext_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_boundary && !req_valid && !((|sts_fe) && fp_summary) && sts_ee && ext_pend
        |=> req_valid && req_vector == VEC_EXT);

endmodule

// File: tb/sim_async_irq_arbiter.sv
module sim_async_irq_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_line = 1'b0;
    logic        dec_expire = 1'b0;
    logic        sts_ee = 1'b0;
    logic [1:0]  sts_fe = 2'b00;
    logic        fp_summary = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        req_ack = 1'b0;
    logic        req_valid;
    logic [15:0] req_vector;
    logic [31:0] req_stat_set;

    int checks = 0;
    int errors = 0;

    localparam logic [15:0] V_FP  = 16'h0700;
    localparam logic [15:0] V_EXT = 16'h0500;
    localparam logic [15:0] V_DEC = 16'h0900;
    localparam logic [31:0] S_FP  = 32'h0001_0800;

    logic [47:0] exp_q[$];
    string       tag_q[$];
    bit          seen = 1'b0;

    always #2.5 clk = ~clk;

    async_irq_arbiter u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_line      (ext_line),
        .dec_expire    (dec_expire),
        .sts_ee        (sts_ee),
        .sts_fe        (sts_fe),
        .fp_summary    (fp_summary),
        .insn_boundary (insn_boundary),
        .req_ack       (req_ack),
        .req_valid     (req_valid),
        .req_vector    (req_vector),
        .req_stat_set  (req_stat_set)
    );

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver side: push the request the next boundary must produce
    task automatic expect_req(input logic [15:0] vec, input logic [31:0] set, input string tag);
        exp_q.push_back({vec, set});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk) insn_boundary = 1'b1;
        @(negedge clk) insn_boundary = 1'b0;
    endtask

    task automatic dec_pulse();
        @(negedge clk) dec_expire = 1'b1;
        @(negedge clk) dec_expire = 1'b0;
    endtask

    // Acknowledge; entry clears the enable bit when drop_ee is set
    task automatic ack(input bit drop_ee);
        @(negedge clk) begin
            req_ack = 1'b1;
            if (drop_ee) sts_ee = 1'b0;
        end
        @(negedge clk) req_ack = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        check(req_valid == 1'b0, tag, {47'd0, req_valid}, 48'd0);
    endtask

    // Monitor: every new request is compared with the head of the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && !seen) begin
                seen = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected request", {req_vector, req_stat_set}, 48'd0);
                end else begin
                    logic [47:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({req_vector, req_stat_set} == e, t, {req_vector, req_stat_set}, e);
                end
            end else if (!req_valid) begin
                seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        check(req_valid == 1'b0, "R1 reset req_valid", {47'd0, req_valid}, 48'd0);
        @(negedge clk) rst_n = 1'b1;
        sts_ee = 1'b1;
        boundary();
        expect_none("R1 nothing pending after reset");

        // External with enable: delivered, stays pending after ack (R5, R6)
        @(negedge clk) ext_line = 1'b1;
        expect_req(V_EXT, 32'd0, "R5 external vector");
        boundary();
        idle(2);
        ack(1'b0);
        expect_req(V_EXT, 32'd0, "R6 external still pending after ack");
        boundary();
        ack(1'b1);
        boundary();
        expect_none("R4 enable cleared by entry blocks external");
        @(negedge clk) ext_line = 1'b0;
        @(negedge clk) sts_ee = 1'b1;
        boundary();
        expect_none("R6 external cleared on line fall");

        // Timer is taken once (R7)
        dec_pulse();
        expect_req(V_DEC, 32'd0, "R5 timer vector");
        boundary();
        ack(1'b0);
        boundary();
        expect_none("R7 timer consumed by ack");

        // Both pending: external first, then timer (R5)
        @(negedge clk) ext_line = 1'b1;
        dec_pulse();
        expect_req(V_EXT, 32'd0, "R5 external beats timer");
        boundary();
        @(negedge clk) ext_line = 1'b0;
        ack(1'b0);
        expect_req(V_DEC, 32'd0, "R5 timer after external");
        boundary();
        ack(1'b0);
        boundary();
        expect_none("R7 no timer left");

        // Floating-point condition beats all, enable ignored (R3)
        @(negedge clk) begin
            sts_ee = 1'b0;
            sts_fe = 2'b01;
            fp_summary = 1'b1;
        end
        expect_req(V_FP, S_FP, "R3 fp with enable off");
        boundary();
        ack(1'b0);
        @(negedge clk) begin
            sts_fe = 2'b10;
            sts_ee = 1'b1;
            ext_line = 1'b1;
        end
        expect_req(V_FP, S_FP, "R3 fp beats external");
        boundary();
        ack(1'b0);
        @(negedge clk) begin
            sts_fe = 2'b00;
            ext_line = 1'b0;
        end
        idle(1);
        boundary();
        expect_none("R3 fp mode off means no fp request");

        // Pending while disabled, then enabled (R8)
        @(negedge clk) sts_ee = 1'b0;
        dec_pulse();
        boundary();
        expect_none("R4 timer held back while disabled");
        @(negedge clk) sts_ee = 1'b1;
        expect_req(V_DEC, 32'd0, "R8 timer delivered after enable");
        boundary();
        ack(1'b0);

        // One outstanding request only (R9)
        @(negedge clk) ext_line = 1'b1;
        expect_req(V_EXT, 32'd0, "R9 first request");
        boundary();
        dec_pulse();
        boundary();
        boundary();
        check(req_valid == 1'b1 && req_vector == V_EXT, "R9 held request unchanged",
              {31'd0, req_valid, req_vector}, {31'd0, 1'b1, V_EXT});
        @(negedge clk) ext_line = 1'b0;
        ack(1'b0);
        expect_none("R2 request dropped after ack");
        expect_req(V_DEC, 32'd0, "R9 queued-free timer later");
        boundary();

        // Expiry in the ack cycle keeps the timer pending (R7)
        @(negedge clk) begin
            req_ack = 1'b1;
            dec_expire = 1'b1;
        end
        @(negedge clk) begin
            req_ack = 1'b0;
            dec_expire = 1'b0;
        end
        expect_req(V_DEC, 32'd0, "R7 expiry during ack kept");
        boundary();
        ack(1'b0);
        boundary();
        expect_none("R7 timer finally consumed");

        // No boundary, no request (R2)
        dec_pulse();
        idle(4);
        expect_none("R2 no request without boundary");

        idle(2);
        check(exp_q.size() == 0, "R2 all expected requests seen", 48'(exp_q.size()), 48'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule